// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block is the register file of an I/O interrupt controller. Software reaches it through two bus locations. A select register names an internal register. A data window then reads or writes the named register 32 bits at a time. Behind the window are an identification register, a read-only version register, a read-only arbitration register that mirrors the identification value, and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves.

Every field of every entry is presented in parallel to the delivery logic beside this block. The delivery logic owns two status bits in each entry: the delivery-status bit, which it drives as a level, and the remote-IRR bit, which it sets and clears with pulses. Software writes cannot alter either bit. There is one exception: a write that leaves an entry edge-triggered clears its remote-IRR bit. The block also reports two kinds of event to the delivery logic. One is a request to re-examine a level-triggered pin whose request line is still high after reprogramming. The other is a notice that a write changed an entry's mask bit.

Top module: `irq_redir_regs`

## Requirements
- R1: Only the bus byte offsets 0x00 and 0x10 are decoded. Offset 0x00 is the 8-bit select register: it reads back zero-extended, and a write keeps `wdata_i[7:0]`. Offset 0x10 is the data window. Any other offset reads as zero, and a write to it changes nothing. Read data appears on `rdata_o` one cycle after `rd_i` and holds until the next read.
- R2: Select 0x00 is the identification register. Bits 27:24 are read/write and all other bits read as zero. Select 0x02 returns the same identification value in bits 27:24, and a write to it is ignored.
- R3: Select 0x01 returns (entry count − 1) in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits zero. A write to it is ignored.
- R4: A select value s ≥ 0x10 addresses entry (s − 0x10) >> 1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. A write replaces only that half.
- R5: Two kinds of select value read as 0xFFFFFFFF: one whose entry index is at or beyond the entry count, and one in the range 0x03 to 0x0F. A write through such a select changes no entry and raises no event.
- R6: Entry fields, as seen by the delivery logic and by reads, sit at these positions:
  - vector: 7:0
  - delivery mode: 10:8
  - destination mode: 11
  - delivery status: 12
  - polarity: 13
  - remote-IRR: 14
  - trigger mode: 15 (1 = level, 0 = edge)
  - mask: 16
  - destination: 63:56
- R7: Software writes never change the delivery-status bit or the remote-IRR bit. Delivery status follows `deliv_stat_i` one cycle later. A pulse on `rirr_set_i` sets remote-IRR and a pulse on `rirr_clr_i` clears it; clear wins if both pulse together.
- R8: A write that leaves an entry in edge mode clears its remote-IRR bit.
- R9: After reset, every entry is zero except its mask bit, which is set. The select register, the identification register, the read data and both event outputs are also zero.
- R10: A write that leaves an entry in level mode while that pin's `req_i` bit is high pulses `svc_req_o` for one cycle, the cycle after the write, with the pin in `svc_pin_o`. The mask bit does not affect this.
- R11: A write that changes an entry's mask bit pulses `mask_chg_o` for one cycle, the cycle after the write. `mask_chg_pin_o` carries the pin and `mask_chg_val_o` carries the new mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Low byte of the bus address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| req_i | input | 24 | Request level of each pin, from the delivery logic |
| deliv_stat_i | input | 24 | Delivery status of each pin, from the delivery logic |
| rirr_set_i | input | 24 | Sets the remote-IRR bit of a pin |
| rirr_clr_i | input | 24 | Clears the remote-IRR bit of a pin |
| vector_o | output | 192 | Vector of each entry, 8 bits per pin |
| deliv_mode_o | output | 72 | Delivery mode of each entry, 3 bits per pin |
| dest_mode_o | output | 24 | Destination mode of each entry |
| deliv_stat_o | output | 24 | Delivery-status bit of each entry |
| polarity_o | output | 24 | Polarity of each entry |
| remote_irr_o | output | 24 | Remote-IRR bit of each entry |
| trig_mode_o | output | 24 | Trigger mode of each entry, 1 = level |
| mask_o | output | 24 | Mask bit of each entry |
| dest_o | output | 192 | Destination of each entry, 8 bits per pin |
| svc_req_o | output | 1 | Pulse: a level pin needs service |
| svc_pin_o | output | 5 | Pin for `svc_req_o` |
| mask_chg_o | output | 1 | Pulse: a write changed a mask bit |
| mask_chg_pin_o | output | 5 | Pin for `mask_chg_o` |
| mask_chg_val_o | output | 1 | New mask value for `mask_chg_o` |

## Verification
Entry accesses are tried on an entry in the middle of the table and on the last entry, using both the even and the odd select. This separates half steering from index arithmetic and exposes any off-by-one at the table end.

Select values are also driven just past the table end, below the entry base, and at the maximum byte value. These cases separate true range checking from plain truncation of the index.

The status-bit cases exercise the protected bits in four ways: writing them with values opposite to their current ones, writing the half that does not hold them, pulsing the set and clear inputs, and rewriting the entry in edge mode. Together these show which source owns each bit.

Event cases repeat the same write with and without a real mask change, and with and without a pending request or level mode. This shows that each pulse depends on its own condition and on nothing else.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0] OFS_SEL      = 8'h00;
  localparam logic [7:0] OFS_WIN      = 8'h10;
  localparam logic [7:0] SEL_ID       = 8'h00;
  localparam logic [7:0] SEL_VER      = 8'h01;
  localparam logic [7:0] SEL_ARB      = 8'h02;
  localparam logic [7:0] SEL_ENT_BASE = 8'h10;

  // bit layout is decoded by the delivery logic; keep positions fixed
  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        trig;   // 1 = level
    logic        rirr;
    logic        pol;
    logic        stat;
    logic        dstm;
    logic [2:0]  dmode;
    logic [7:0]  vec;
  } redir_ent_t;

  typedef enum logic [2:0] {
    SK_ID, SK_VER, SK_ARB, SK_ENT, SK_BAD
  } sel_kind_e;

  function automatic redir_ent_t ent_reset();
    redir_ent_t e;
    e = '0;
    e.mask = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/irq_redir_sel_decode.sv
module irq_redir_sel_decode
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [7:0]       sel_i,
  output sel_kind_e        kind_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  logic [7:0] off;
  logic [7:0] raw_idx;

  assign off     = sel_i - SEL_ENT_BASE;
  assign raw_idx = {1'b0, off[7:1]};
  assign idx_o   = raw_idx[IDX_W-1:0];
  assign hi_o    = sel_i[0];

  always_comb begin
    if (sel_i == SEL_ID)                              kind_o = SK_ID;
    else if (sel_i == SEL_VER)                        kind_o = SK_VER;
    else if (sel_i == SEL_ARB)                        kind_o = SK_ARB;
    else if (sel_i >= SEL_ENT_BASE &&
             32'(raw_idx) < N_ENTRIES)                kind_o = SK_ENT;
    else                                              kind_o = SK_BAD;
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rirr_set_i,
  input  logic        rirr_clr_i,
  input  logic        stat_i,
  input  logic        req_i,
  output redir_ent_t  ent_o,
  output logic        mask_flip_o,
  output logic        svc_hit_o
);
  redir_ent_t ent_q, ent_n, wr_val;
  logic       written;

  assign written = wr_lo_i | wr_hi_i;

  always_comb begin
    wr_val = ent_q;
    if (wr_lo_i) wr_val[31:0]  = wdata_i;
    if (wr_hi_i) wr_val[63:32] = wdata_i;

    ent_n      = wr_val;
    ent_n.stat = stat_i;
    if (rirr_clr_i)      ent_n.rirr = 1'b0;
    else if (rirr_set_i) ent_n.rirr = 1'b1;
    else                 ent_n.rirr = ent_q.rirr;
    if (written && !wr_val.trig) ent_n.rirr = 1'b0;
  end

  assign mask_flip_o = written && (wr_val.mask != ent_q.mask);
  assign svc_hit_o   = written && wr_val.trig && req_i;
  assign ent_o       = ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= ent_reset();
    else         ent_q <= ent_n;
  end

  assert_edge_write_clears_rirr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wdata_i[15]) |=> !ent_q.rirr);

  assert_write_keeps_rirr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (written && !rirr_set_i && !rirr_clr_i) |=> (!ent_q.trig || ent_q.rirr == $past(ent_q.rirr)));

  assert_stat_follows_input_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ent_q.stat == $past(stat_i));

  assert_hi_write_keeps_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> (ent_q.vec == $past(ent_q.vec) && ent_q.mask == $past(ent_q.mask)
                               && ent_q.trig == $past(ent_q.trig)));
endmodule

// File: rtl/irq_redir_evt.sv
module irq_redir_evt #(
  parameter int unsigned N_ENTRIES = 24,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] flip_i,
  input  logic [N_ENTRIES-1:0] old_mask_i,
  input  logic [N_ENTRIES-1:0] svc_i,
  output logic                 mask_chg_o,
  output logic [IDX_W-1:0]     mask_chg_pin_o,
  output logic                 mask_chg_val_o,
  output logic                 svc_req_o,
  output logic [IDX_W-1:0]     svc_pin_o
);
  logic [IDX_W-1:0] flip_pin, svc_pin;
  logic             flip_val;

  // at most one entry is written per cycle, so a plain encoder suffices
  always_comb begin
    flip_pin = '0;
    svc_pin  = '0;
    flip_val = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (flip_i[i]) begin
        flip_pin = IDX_W'(i);
        flip_val = ~old_mask_i[i];
      end
      if (svc_i[i]) svc_pin = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_chg_o     <= 1'b0;
      mask_chg_pin_o <= '0;
      mask_chg_val_o <= 1'b0;
      svc_req_o      <= 1'b0;
      svc_pin_o      <= '0;
    end else begin
      mask_chg_o     <= |flip_i;
      mask_chg_pin_o <= flip_pin;
      mask_chg_val_o <= flip_val;
      svc_req_o      <= |svc_i;
      svc_pin_o      <= svc_pin;
    end
  end

  assert_single_flip_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flip_i));

  assert_single_svc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(svc_i));
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 24,
  parameter logic [7:0]  VER_CODE  = 8'h11,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             addr_i,
  input  logic [31:0]            wdata_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  output logic [31:0]            rdata_o,
  input  logic [N_ENTRIES-1:0]   req_i,
  input  logic [N_ENTRIES-1:0]   deliv_stat_i,
  input  logic [N_ENTRIES-1:0]   rirr_set_i,
  input  logic [N_ENTRIES-1:0]   rirr_clr_i,
  output logic [N_ENTRIES*8-1:0] vector_o,
  output logic [N_ENTRIES*3-1:0] deliv_mode_o,
  output logic [N_ENTRIES-1:0]   dest_mode_o,
  output logic [N_ENTRIES-1:0]   deliv_stat_o,
  output logic [N_ENTRIES-1:0]   polarity_o,
  output logic [N_ENTRIES-1:0]   remote_irr_o,
  output logic [N_ENTRIES-1:0]   trig_mode_o,
  output logic [N_ENTRIES-1:0]   mask_o,
  output logic [N_ENTRIES*8-1:0] dest_o,
  output logic                   svc_req_o,
  output logic [IDX_W-1:0]       svc_pin_o,
  output logic                   mask_chg_o,
  output logic [IDX_W-1:0]       mask_chg_pin_o,
  output logic                   mask_chg_val_o
);
  localparam logic [7:0] MAX_IDX = 8'(N_ENTRIES - 1);

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  sel_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             hi;
  logic             wr_sel, wr_win;
  logic [31:0]      rd_val, ent_half;

  redir_ent_t           ent [N_ENTRIES];
  logic [N_ENTRIES-1:0] flip, svc;

  assign wr_sel = wr_i && (addr_i == OFS_SEL);
  assign wr_win = wr_i && (addr_i == OFS_WIN);

  irq_redir_sel_decode #(.N_ENTRIES(N_ENTRIES)) u_dec (
    .sel_i  (sel_q),
    .kind_o (kind),
    .idx_o  (idx),
    .hi_o   (hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= wdata_i[7:0];
      if (wr_win && kind == SK_ID) id_q <= wdata_i[27:24];
    end
  end

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic hit;
    assign hit = wr_win && (kind == SK_ENT) && (idx == IDX_W'(i));

    irq_redir_entry u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_lo_i     (hit && !hi),
      .wr_hi_i     (hit && hi),
      .wdata_i     (wdata_i),
      .rirr_set_i  (rirr_set_i[i]),
      .rirr_clr_i  (rirr_clr_i[i]),
      .stat_i      (deliv_stat_i[i]),
      .req_i       (req_i[i]),
      .ent_o       (ent[i]),
      .mask_flip_o (flip[i]),
      .svc_hit_o   (svc[i])
    );

    assign vector_o[i*8 +: 8]     = ent[i].vec;
    assign deliv_mode_o[i*3 +: 3] = ent[i].dmode;
    assign dest_mode_o[i]         = ent[i].dstm;
    assign deliv_stat_o[i]        = ent[i].stat;
    assign polarity_o[i]          = ent[i].pol;
    assign remote_irr_o[i]        = ent[i].rirr;
    assign trig_mode_o[i]         = ent[i].trig;
    assign mask_o[i]              = ent[i].mask;
    assign dest_o[i*8 +: 8]       = ent[i].dest;
  end

  irq_redir_evt #(.N_ENTRIES(N_ENTRIES)) u_evt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flip_i         (flip),
    .old_mask_i     (mask_o),
    .svc_i          (svc),
    .mask_chg_o     (mask_chg_o),
    .mask_chg_pin_o (mask_chg_pin_o),
    .mask_chg_val_o (mask_chg_val_o),
    .svc_req_o      (svc_req_o),
    .svc_pin_o      (svc_pin_o)
  );

  always_comb begin
    ent_half = '0;
    for (int i = 0; i < N_ENTRIES; i++)
      if (idx == IDX_W'(i)) ent_half = hi ? ent[i][63:32] : ent[i][31:0];
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == OFS_SEL) rd_val = {24'h0, sel_q};
    else if (addr_i == OFS_WIN) begin
      case (kind)
        SK_ID, SK_ARB: rd_val = {4'h0, id_q, 24'h0};
        SK_VER:        rd_val = {8'h0, MAX_IDX, 8'h0, VER_CODE};
        SK_ENT:        rd_val = ent_half;
        default:       rd_val = '1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assert_rdata_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_svc_pin_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_req_o |-> trig_mode_o[svc_pin_o]);

  assert_mask_evt_value_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |-> (mask_o[mask_chg_pin_o] == mask_chg_val_o));

  assert_bad_sel_no_evt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_WIN && (sel_q > SEL_ARB) &&
     (sel_q < SEL_ENT_BASE || ((sel_q - SEL_ENT_BASE) >> 1) > MAX_IDX))
    |=> (!mask_chg_o && !svc_req_o));

  assert_id_write_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_WIN && sel_q == SEL_ARB) |=> $stable(id_q));
endmodule

// File: tb/irq_redir_regs_test.sv
module irq_redir_regs_test;
  localparam int N = 24;
  localparam int W = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic           wr = 1'b0, rd = 1'b0;
  logic [31:0]    rdata;
  logic [N-1:0]   req = '0, dstat = '0, rset = '0, rclr = '0;
  logic [N*8-1:0] vector, dest;
  logic [N*3-1:0] dmode;
  logic [N-1:0]   dstm, stat_o, pol, rirr, trig, mask;
  logic           svc, mchg, mval;
  logic [W-1:0]   svc_pin, mpin;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_redir_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .req_i(req), .deliv_stat_i(dstat), .rirr_set_i(rset), .rirr_clr_i(rclr),
    .vector_o(vector), .deliv_mode_o(dmode), .dest_mode_o(dstm), .deliv_stat_o(stat_o),
    .polarity_o(pol), .remote_irr_o(rirr), .trig_mode_o(trig), .mask_o(mask), .dest_o(dest),
    .svc_req_o(svc), .svc_pin_o(svc_pin), .mask_chg_o(mchg), .mask_chg_pin_o(mpin),
    .mask_chg_val_o(mval)
  );

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic win_wr(logic [7:0] s, logic [31:0] d);
    bus_wr(8'h00, {24'h0, s});
    bus_wr(8'h10, d);
  endtask

  task automatic win_rd(logic [7:0] s);
    bus_wr(8'h00, {24'h0, s});
    bus_rd(8'h10);
  endtask

  task automatic t_reset_r9();
    chk("R9 rdata", rdata, 0);
    chk("R9 masks", 32'(mask), 32'(24'hFFFFFF));
    chk("R9 rirr", 32'(rirr), 0);
    chk("R9 events", {30'h0, svc, mchg}, 0);
    bus_rd(8'h00);
    chk("R9 select", rdata, 0);
    bus_rd(8'h10);
    chk("R9 id", rdata, 0);
  endtask

  task automatic t_window_r1();
    bus_wr(8'h00, 32'h1FF);
    bus_rd(8'h00);
    chk("R1 select 8-bit", rdata, 32'hFF);
    bus_wr(8'h20, 32'hAB);
    bus_rd(8'h00);
    chk("R1 other offset write ignored", rdata, 32'hFF);
    bus_rd(8'h20);
    chk("R1 other offset reads zero", rdata, 0);
    bus_rd(8'h00);
    @(negedge clk); addr = 8'h10;
    repeat (3) @(negedge clk);
    chk("R1 rdata holds", rdata, 32'hFF);
  endtask

  task automatic t_id_ver_r2_r3();
    win_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h10);
    chk("R2 id rw", rdata, 32'h0F00_0000);
    win_rd(8'h02);
    chk("R2 arb mirrors id", rdata, 32'h0F00_0000);
    win_wr(8'h02, 32'h0);
    win_rd(8'h00);
    chk("R2 arb write ignored", rdata, 32'h0F00_0000);
    win_rd(8'h01);
    chk("R3 version", rdata, 32'h0017_0011);
    win_wr(8'h01, 32'h0);
    bus_rd(8'h10);
    chk("R3 version write ignored", rdata, 32'h0017_0011);
  endtask

  task automatic t_entry_r4_r6_r11();
    win_wr(8'h1A, 32'h0000_8B42);
    chk("R11 mask clear pulse", {30'h0, mchg, mval}, 32'h2);
    chk("R11 mask pin", 32'(mpin), 5);
    @(negedge clk);
    chk("R11 pulse one cycle", 32'(mchg), 0);
    win_wr(8'h1B, 32'h7F00_0000);
    chk("R11 no pulse without mask change", 32'(mchg), 0);
    win_rd(8'h1B);
    chk("R4 high half", rdata, 32'h7F00_0000);
    win_rd(8'h1A);
    chk("R4 low half kept", rdata, 32'h0000_8B42);
    chk("R6 vector", 32'(vector[5*8 +: 8]), 32'h42);
    chk("R6 dmode", 32'(dmode[5*3 +: 3]), 3);
    chk("R6 bits", {27'h0, dstm[5], pol[5], trig[5], mask[5], stat_o[5]}, 32'b10100);
    chk("R6 dest", 32'(dest[5*8 +: 8]), 32'h7F);
    win_wr(8'h1A, 32'h0001_8B42);
    chk("R11 mask set pulse", {27'h0, mpin, mchg, mval}, {27'h0, 5'd5, 2'b11});
    win_wr(8'h3F, 32'hC300_0000);
    win_rd(8'h3F);
    chk("R4 last entry high", rdata, 32'hC300_0000);
    win_rd(8'h3E);
    chk("R4 last entry low", rdata, 32'h0001_0000);
    chk("R6 last dest", 32'(dest[23*8 +: 8]), 32'hC3);
  endtask

  task automatic t_oob_r5();
    win_wr(8'h40, 32'h0);
    chk("R5 oob write no event", 32'(mchg), 0);
    chk("R5 oob write no change", 32'(mask[23]), 1);
    bus_rd(8'h10);
    chk("R5 index 24 reads ones", rdata, 32'hFFFF_FFFF);
    win_rd(8'h05);
    chk("R5 low select reads ones", rdata, 32'hFFFF_FFFF);
    win_rd(8'hFF);
    chk("R5 max select reads ones", rdata, 32'hFFFF_FFFF);
    win_rd(8'h3E);
    chk("R5 neighbour intact", rdata, 32'h0001_0000);
  endtask

  task automatic t_status_r7_r8();
    win_wr(8'h16, 32'h0000_8020);
    @(negedge clk); rset[3] = 1'b1;
    @(negedge clk); rset[3] = 1'b0;
    chk("R7 rirr set", 32'(rirr[3]), 1);
    win_wr(8'h16, 32'h0000_9020);
    win_rd(8'h16);
    chk("R7 status bits protected", rdata, 32'h0000_C020);
    @(negedge clk); dstat[3] = 1'b1;
    win_rd(8'h16);
    chk("R7 status follows input", rdata, 32'h0000_D020);
    win_wr(8'h17, 32'h1100_0000);
    chk("R7 rirr kept over high write", 32'(rirr[3]), 1);
    @(negedge clk); rclr[3] = 1'b1; rset[3] = 1'b1;
    @(negedge clk); rclr[3] = 1'b0; rset[3] = 1'b0;
    chk("R7 clear wins", 32'(rirr[3]), 0);
    @(negedge clk); rset[3] = 1'b1;
    @(negedge clk); rset[3] = 1'b0;
    win_wr(8'h16, 32'h0000_4020);
    chk("R8 edge write clears rirr", 32'(rirr[3]), 0);
    win_rd(8'h16);
    chk("R8 status still set", rdata, 32'h0000_1020);
    @(negedge clk); dstat[3] = 1'b0;
  endtask

  task automatic t_service_r10();
    @(negedge clk); req[7] = 1'b1;
    win_wr(8'h1E, 32'h0001_8033);
    chk("R10 level write with request", {27'h0, svc_pin, svc}, {27'h0, 5'd7, 1'b1});
    chk("R11 mask unchanged no pulse", 32'(mchg), 0);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(svc), 0);
    win_wr(8'h1E, 32'h0001_0033);
    chk("R10 edge write no request", 32'(svc), 0);
    @(negedge clk); req[7] = 1'b0;
    win_wr(8'h1E, 32'h0001_8033);
    chk("R10 no request line", 32'(svc), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r9();
    t_window_r1();
    t_id_ver_r2_r3();
    t_entry_r4_r6_r11();
    t_oob_r5();
    t_status_r7_r8();
    t_service_r10();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule